// File: doc/BRIEF.md
# Event Record Framing Checker

This block sits behind a serial-link receiver. It checks the framing of one event record at a time. A record opens with a begin marker strobe and closes with an end marker strobe. Between them come data bytes: a fixed 12-byte header, a run of equal-size objects, a 4-byte logical trailer, and zero padding up to the next 16-byte boundary. The number of objects in a record arrives on a sideband input that is latched with the begin marker.

While the bytes stream in, the block captures the header fields and publishes them. It keeps two running XOR accumulators, one for bytes at even positions and one for bytes at odd positions. It finds the trailer at the offset given by the object count and the object length. At the end marker it publishes one flag per check and pulses a done strobe. A downstream consumer reads the verdict and the header fields in that cycle.

Top module: `evrec_frame_chk`

## Requirements
- R1: Header bytes are numbered from 0 in arrival order, and each is captured as it arrives. Byte 1 goes to `hdr_words`, byte 2 to `obj_words`, byte 4 to `data_type` and byte 5 to `bunch_num`. Byte 3 is split: bits 7:5 go to `fmt_hdr` and bits 4:0 go to `fmt_obj`. `rotation` is byte 7 in its upper half and byte 6 in its lower half. Byte 11 goes to `status`.
- R2: `st_event_err` mirrors bit 7 of the captured status byte, and `st_sim` mirrors bit 0.
- R3: The trailer starts at byte index 12 + N·L·4. N is `obj_count`, sampled in the cycle of the begin marker, and L is header byte 2.
- R4: `err_trailer` is set when trailer byte 0 differs from header byte 5, or when trailer byte 1 differs from header byte 4.
- R5: `err_par_even` is set when trailer byte 2 differs from the XOR of all bytes with even index below the trailer start.
- R6: `err_par_odd` is set when trailer byte 3 differs from the XOR of all bytes with odd index below the trailer start.
- R7: `err_pad` is set when any byte after the trailer is nonzero.
- R8: `err_length` is set when the byte count is not a multiple of 16, or when the record ends before its 4 trailer bytes have arrived.
- R9: `err_oversize` is set when more than 4096 bytes arrive. Bytes past the 4096th are not checked and are not counted.
- R10: A begin marker inside an open record closes that record with `err_reframe` set and a done pulse, then opens a new record. Checks on the new record start clean.
- R11: `rec_done` is high for exactly one cycle, the cycle after the closing marker. All error flags change only in that cycle and hold until the next one. An end marker outside a record causes no done pulse.
- R12: Data bytes outside a record leave every output unchanged.
- R13: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A data byte is present |
| byte_data | input | 8 | Data byte |
| evt_begin | input | 1 | Begin-of-record marker strobe |
| evt_end | input | 1 | End-of-record marker strobe |
| obj_count | input | CNT_W | Object count, sampled with the begin marker |
| hdr_words | output | 8 | Header length in 4-byte words |
| obj_words | output | 8 | Object length in 4-byte words |
| fmt_hdr | output | 3 | Header/trailer format number |
| fmt_obj | output | 5 | Object format number |
| data_type | output | 8 | Data type |
| bunch_num | output | 8 | Bunch number |
| rotation | output | 16 | Rotation number |
| status | output | 8 | Status byte |
| st_event_err | output | 1 | Status bit 7: event has an error |
| st_sim | output | 1 | Status bit 0: simulated data |
| err_trailer | output | 1 | Trailer does not repeat the header |
| err_par_even | output | 1 | Even-position parity mismatch |
| err_par_odd | output | 1 | Odd-position parity mismatch |
| err_pad | output | 1 | Nonzero padding byte |
| err_length | output | 1 | Bad length or trailer missing |
| err_oversize | output | 1 | Record longer than 4096 bytes |
| err_reframe | output | 1 | Record cut short by a new begin marker |
| rec_done | output | 1 | One-cycle verdict strobe |

## Verification
A byte index that drifts by one moves the trailer window. The trailer, parity and padding flags then go wrong together on the very next `rec_done`. A parity lane that is not cleared at the begin marker stays hidden until the following record, where its parity flag rises while the trailer flag stays clear. A lost record-open state shows within one cycle: either the done pulse is missing after the end marker, or idle bytes overwrite the header fields. Stale sticky errors show up as flags set on a clean record that follows a corrupted one. For that reason the bench sends clean and corrupted records back to back.

// File: rtl/evrec_pkg.sv
package evrec_pkg;

  localparam int unsigned HDR_BYTES = 12;
  localparam int unsigned TRL_BYTES = 4;

  typedef struct packed {
    logic [2:0]  fmt_hdr;
    logic [4:0]  fmt_obj;
    logic [7:0]  hdr_words;
    logic [7:0]  obj_words;
    logic [7:0]  dtype;
    logic [7:0]  bunch;
    logic [15:0] rot;
    logic [7:0]  status;
  } evrec_hdr_t;

  typedef struct packed {
    logic trl;
    logic par_even;
    logic par_odd;
    logic pad;
    logic len;
    logic big;
    logic reframe;
  } evrec_err_t;

endpackage

// File: rtl/evrec_hdr_cap.sv
module evrec_hdr_cap
  import evrec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [3:0]  pos,
  input  logic [7:0]  din,
  output evrec_hdr_t  hdr
);

  evrec_hdr_t hdr_q, hdr_d;

  always_comb begin
    hdr_d = hdr_q;
    if (cap_en) begin
      case (pos)
        4'd1:  hdr_d.hdr_words = din;
        4'd2:  hdr_d.obj_words = din;
        4'd3:  {hdr_d.fmt_hdr, hdr_d.fmt_obj} = din;
        4'd4:  hdr_d.dtype = din;
        4'd5:  hdr_d.bunch = din;
        4'd6:  hdr_d.rot[7:0] = din;
        4'd7:  hdr_d.rot[15:8] = din;
        4'd11: hdr_d.status = din;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_q <= '0;
    else        hdr_q <= hdr_d;
  end

  assign hdr = hdr_q;

endmodule

// File: rtl/evrec_lpar.sv
module evrec_lpar (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            lane,
  input  logic [7:0]      din,
  output logic [1:0][7:0] acc
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] acc_q, acc_d;

    always_comb begin
      acc_d = acc_q;
      if (clr)                             acc_d = '0;
      else if (en && (int'(lane) == g))    acc_d = acc_q ^ din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    assign acc[g] = acc_q;
  end

endmodule

// File: rtl/evrec_ctl.sv
module evrec_ctl
  import evrec_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_BYTES = 4096,
  parameter int unsigned ALIGN     = 16,
  localparam int unsigned IW  = $clog2(MAX_BYTES + 1),
  localparam int unsigned TPW = CNT_W + 8 + 3,
  localparam int unsigned AW  = $clog2(ALIGN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             evt_begin,
  input  logic             evt_end,
  input  logic [CNT_W-1:0] obj_count,
  input  logic [7:0]       olen,
  input  logic [7:0]       bunch,
  input  logic [7:0]       dtype,
  input  logic [1:0][7:0]  par,
  output logic             in_rec,
  output logic             hdr_en,
  output logic [3:0]       hdr_pos,
  output logic             par_clr,
  output logic             par_en,
  output logic             par_lane,
  output evrec_err_t       errs,
  output logic             done
);

  logic             in_rec_q, in_rec_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trl_q, trl_d, pe_q, pe_d, po_q, po_d, pad_q, pad_d, big_q, big_d;
  evrec_err_t       err_q, err_d;
  logic             done_q, done_d;

  logic [TPW-1:0] prod, tpos, idx_w;
  logic           byte_ok, take, over, len_bad;

  assign prod    = TPW'(cnt_q) * TPW'(olen);
  assign tpos    = TPW'(HDR_BYTES) + (prod << 2);
  assign idx_w   = TPW'(idx_q);
  assign byte_ok = byte_vld && in_rec_q && !evt_begin && !evt_end;
  assign take    = byte_ok && (idx_q < IW'(MAX_BYTES));
  assign over    = byte_ok && !take;
  assign len_bad = (idx_q[AW-1:0] != '0) || (idx_w < tpos + TPW'(TRL_BYTES));

  always_comb begin
    in_rec_d = in_rec_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    trl_d    = trl_q;
    pe_d     = pe_q;
    po_d     = po_q;
    pad_d    = pad_q;
    big_d    = big_q;
    err_d    = err_q;
    done_d   = 1'b0;
    if (evt_begin) begin
      if (in_rec_q) begin
        err_d  = '{trl_q, pe_q, po_q, pad_q, len_bad, big_q, 1'b1};
        done_d = 1'b1;
      end
      in_rec_d = 1'b1;
      idx_d    = '0;
      cnt_d    = obj_count;
      trl_d    = 1'b0;
      pe_d     = 1'b0;
      po_d     = 1'b0;
      pad_d    = 1'b0;
      big_d    = 1'b0;
    end else if (evt_end && in_rec_q) begin
      err_d    = '{trl_q, pe_q, po_q, pad_q, len_bad, big_q, 1'b0};
      done_d   = 1'b1;
      in_rec_d = 1'b0;
    end else if (take) begin
      idx_d = idx_q + 1'b1;
      if (idx_w == tpos) begin
        if (byte_data != bunch) trl_d = 1'b1;
      end else if (idx_w == tpos + TPW'(1)) begin
        if (byte_data != dtype) trl_d = 1'b1;
      end else if (idx_w == tpos + TPW'(2)) begin
        if (byte_data != par[0]) pe_d = 1'b1;
      end else if (idx_w == tpos + TPW'(3)) begin
        if (byte_data != par[1]) po_d = 1'b1;
      end else if (idx_w > tpos) begin
        if (byte_data != 8'd0) pad_d = 1'b1;
      end
    end else if (over) begin
      big_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rec_q <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      trl_q    <= 1'b0;
      pe_q     <= 1'b0;
      po_q     <= 1'b0;
      pad_q    <= 1'b0;
      big_q    <= 1'b0;
      err_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      in_rec_q <= in_rec_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
      trl_q    <= trl_d;
      pe_q     <= pe_d;
      po_q     <= po_d;
      pad_q    <= pad_d;
      big_q    <= big_d;
      err_q    <= err_d;
      done_q   <= done_d;
    end
  end

  assign in_rec   = in_rec_q;
  assign hdr_en   = take && (idx_q < IW'(HDR_BYTES));
  assign hdr_pos  = idx_q[3:0];
  assign par_clr  = evt_begin;
  assign par_en   = take && (idx_w < tpos);
  assign par_lane = idx_q[0];
  assign errs     = err_q;
  assign done     = done_q;

endmodule

// File: rtl/evrec_frame_chk.sv
module evrec_frame_chk
  import evrec_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_BYTES = 4096,
  parameter int unsigned ALIGN     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_data,
  input  logic             evt_begin,
  input  logic             evt_end,
  input  logic [CNT_W-1:0] obj_count,
  output logic [7:0]       hdr_words,
  output logic [7:0]       obj_words,
  output logic [2:0]       fmt_hdr,
  output logic [4:0]       fmt_obj,
  output logic [7:0]       data_type,
  output logic [7:0]       bunch_num,
  output logic [15:0]      rotation,
  output logic [7:0]       status,
  output logic             st_event_err,
  output logic             st_sim,
  output logic             err_trailer,
  output logic             err_par_even,
  output logic             err_par_odd,
  output logic             err_pad,
  output logic             err_length,
  output logic             err_oversize,
  output logic             err_reframe,
  output logic             rec_done
);

  evrec_hdr_t      hdr;
  evrec_err_t      errs;
  logic [1:0][7:0] par;
  logic            in_rec, hdr_en, par_clr, par_en, par_lane;
  logic [3:0]      hdr_pos;

  evrec_ctl #(
    .CNT_W     (CNT_W),
    .MAX_BYTES (MAX_BYTES),
    .ALIGN     (ALIGN)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .evt_begin (evt_begin),
    .evt_end   (evt_end),
    .obj_count (obj_count),
    .olen      (hdr.obj_words),
    .bunch     (hdr.bunch),
    .dtype     (hdr.dtype),
    .par       (par),
    .in_rec    (in_rec),
    .hdr_en    (hdr_en),
    .hdr_pos   (hdr_pos),
    .par_clr   (par_clr),
    .par_en    (par_en),
    .par_lane  (par_lane),
    .errs      (errs),
    .done      (rec_done)
  );

  evrec_hdr_cap u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (hdr_en),
    .pos    (hdr_pos),
    .din    (byte_data),
    .hdr    (hdr)
  );

  evrec_lpar u_par (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (par_clr),
    .en    (par_en),
    .lane  (par_lane),
    .din   (byte_data),
    .acc   (par)
  );

  assign hdr_words    = hdr.hdr_words;
  assign obj_words    = hdr.obj_words;
  assign fmt_hdr      = hdr.fmt_hdr;
  assign fmt_obj      = hdr.fmt_obj;
  assign data_type    = hdr.dtype;
  assign bunch_num    = hdr.bunch;
  assign rotation     = hdr.rot;
  assign status       = hdr.status;
  assign st_event_err = hdr.status[7];
  assign st_sim       = hdr.status[0];
  assign err_trailer  = errs.trl;
  assign err_par_even = errs.par_even;
  assign err_par_odd  = errs.par_odd;
  assign err_pad      = errs.pad;
  assign err_length   = errs.len;
  assign err_oversize = errs.big;
  assign err_reframe  = errs.reframe;

endmodule

// File: rtl/evrec_frame_chk_sva.sv
module evrec_frame_chk_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_begin,
  input logic       evt_end,
  input logic       in_rec,
  input logic       rec_done,
  input logic [7:0] bunch_num,
  input logic [7:0] data_type,
  input logic       err_trailer,
  input logic       err_par_even,
  input logic       err_par_odd,
  input logic       err_pad,
  input logic       err_length,
  input logic       err_oversize,
  input logic       err_reframe
);

  assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> $past(evt_begin || evt_end));

  assert_idle_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && !evt_begin && !in_rec) |=> !rec_done);

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_done |-> $stable({err_trailer, err_par_even, err_par_odd, err_pad,
                           err_length, err_oversize, err_reframe}));

  assert_reframe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && err_reframe) |-> $past(evt_begin));

  assert_begin_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_begin |=> in_rec);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rec |=> $stable({bunch_num, data_type}));

endmodule

bind evrec_frame_chk evrec_frame_chk_sva u_sva (.*);

// File: tb/test_evrec_frame_chk.sv
module test_evrec_frame_chk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, evt_begin, evt_end;
  logic [7:0]  byte_data, obj_count;
  logic [7:0]  hdr_words, obj_words, data_type, bunch_num, status;
  logic [2:0]  fmt_hdr;
  logic [4:0]  fmt_obj;
  logic [15:0] rotation;
  logic        st_event_err, st_sim;
  logic        err_trailer, err_par_even, err_par_odd, err_pad;
  logic        err_length, err_oversize, err_reframe, rec_done;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] rec [0:4199];
  int rlen, rcnt, rtpos;

  always #4 clk = ~clk;

  evrec_frame_chk i_evrec_frame_chk (.*);

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build(int cnt, int olen);
    logic [7:0] pe, po;
    rcnt  = cnt;
    rtpos = 12 + cnt * olen * 4;
    rec[0] = 8'(cnt);
    rec[1] = 8'd3;
    rec[2] = 8'(olen);
    for (int i = 3; i < rtpos; i++) rec[i] = 8'($urandom);
    pe = 8'd0;
    po = 8'd0;
    for (int i = 0; i < rtpos; i++)
      if (i % 2 == 0) pe ^= rec[i]; else po ^= rec[i];
    rec[rtpos]     = rec[5];
    rec[rtpos + 1] = rec[4];
    rec[rtpos + 2] = pe;
    rec[rtpos + 3] = po;
    rlen = ((rtpos + 4 + 15) / 16) * 16;
    for (int i = rtpos + 4; i < rlen; i++) rec[i] = 8'd0;
  endtask

  // expected flags {trl, pe, po, pad, len, big}, computed from the requirements
  function automatic logic [5:0] model(int len, int cnt);
    int n, tp;
    logic [7:0] pe, po;
    logic trl, bpe, bpo, pad;
    n   = (len > 4096) ? 4096 : len;
    tp  = 12 + cnt * rec[2] * 4;
    pe  = 8'd0; po = 8'd0;
    trl = 1'b0; bpe = 1'b0; bpo = 1'b0; pad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i < tp) begin
        if (i % 2 == 0) pe ^= rec[i]; else po ^= rec[i];
      end else if (i == tp) trl |= (rec[i] != rec[5]);
      else if (i == tp + 1) trl |= (rec[i] != rec[4]);
      else if (i == tp + 2) bpe = (rec[i] != pe);
      else if (i == tp + 3) bpo = (rec[i] != po);
      else pad |= (rec[i] != 8'd0);
    end
    return {trl, bpe, bpo, pad, (n % 16 != 0) || (n < tp + 4), len > 4096};
  endfunction

  task automatic send(int from, int len, bit do_begin, bit gaps);
    if (do_begin) begin
      obj_count = 8'(rcnt);
      evt_begin = 1'b1;
      @(negedge clk);
      evt_begin = 1'b0;
    end
    for (int i = from; i < len; i++) begin
      byte_vld  = 1'b1;
      byte_data = rec[i];
      @(negedge clk);
      if (gaps && ($urandom % 8 == 0)) begin
        byte_vld  = 1'b0;
        byte_data = 8'hA5;
        @(negedge clk);
      end
    end
    byte_vld = 1'b0;
    evt_end  = 1'b1;
    @(negedge clk);
    evt_end = 1'b0;
  endtask

  task automatic check_flags(string tag, logic [5:0] e, logic refr);
    chk(tag, "rec_done", int'(rec_done), 1);
    chk(tag, "err_trailer R4", int'(err_trailer), int'(e[5]));
    chk(tag, "err_par_even R5", int'(err_par_even), int'(e[4]));
    chk(tag, "err_par_odd R6", int'(err_par_odd), int'(e[3]));
    chk(tag, "err_pad R7", int'(err_pad), int'(e[2]));
    chk(tag, "err_length R8", int'(err_length), int'(e[1]));
    chk(tag, "err_oversize R9", int'(err_oversize), int'(e[0]));
    chk(tag, "err_reframe R10", int'(err_reframe), int'(refr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; byte_vld = 1'b0; byte_data = 8'd0;
    evt_begin = 1'b0; evt_end = 1'b0; obj_count = 8'd0;
    repeat (3) @(negedge clk);
    chk("R13", "rec_done in reset", int'(rec_done), 0);
    chk("R13", "outputs in reset", int'({hdr_words, obj_words, data_type, bunch_num, rotation,
        status, err_trailer, err_par_even, err_par_odd, err_pad, err_length, err_oversize,
        err_reframe} != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // clean record, header capture
    build(3, 2);
    rec[3] = 8'hB7; rec[11] = 8'h81;
    build_fix();
    send(0, rlen, 1'b1, 1'b0);
    check_flags("R3 clean", model(rlen, rcnt), 1'b0);
    chk("R1", "hdr_words", int'(hdr_words), 3);
    chk("R1", "obj_words", int'(obj_words), 2);
    chk("R1", "fmt_hdr", int'(fmt_hdr), 5);
    chk("R1", "fmt_obj", int'(fmt_obj), 23);
    chk("R1", "data_type", int'(data_type), int'(rec[4]));
    chk("R1", "bunch_num", int'(bunch_num), int'(rec[5]));
    chk("R1", "rotation", int'(rotation), int'({rec[7], rec[6]}));
    chk("R1", "status", int'(status), 8'h81);
    chk("R2", "st_event_err", int'(st_event_err), 1);
    chk("R2", "st_sim", int'(st_sim), 1);
    @(negedge clk);
    chk("R11", "done one cycle", int'(rec_done), 0);
    chk("R11", "flags hold", int'(err_trailer | err_length), 0);

    // idle bytes and idle end marker
    keep = bunch_num;
    byte_vld = 1'b1; byte_data = 8'hFF;
    repeat (8) @(negedge clk);
    byte_vld = 1'b0; evt_end = 1'b1;
    @(negedge clk);
    evt_end = 1'b0;
    chk("R12", "bunch after idle bytes", int'(bunch_num), int'(keep));
    chk("R11", "no done on idle end", int'(rec_done), 0);
    @(negedge clk);
    chk("R11", "no done later", int'(rec_done), 0);

    // directed corruptions
    build(2, 1); rec[rtpos] ^= 8'h01;
    send(0, rlen, 1'b1, 1'b0);
    check_flags("R4 bunch", model(rlen, rcnt), 1'b0);
    chk("R4", "trailer flag", int'(err_trailer), 1);
    build(2, 1); rec[rtpos + 1] ^= 8'h40;
    send(0, rlen, 1'b1, 1'b0);
    chk("R4", "dtype trailer flag", int'(err_trailer), 1);
    build(1, 3); rec[rtpos + 2] ^= 8'h10;
    send(0, rlen, 1'b1, 1'b0);
    check_flags("R5 even", model(rlen, rcnt), 1'b0);
    chk("R5", "even flag", int'(err_par_even), 1);
    build(1, 3); rec[rtpos + 3] ^= 8'h02;
    send(0, rlen, 1'b1, 1'b0);
    chk("R6", "odd flag", int'(err_par_odd), 1);
    chk("R6", "even clean", int'(err_par_even), 0);
    build(1, 1); rec[rlen - 1] = 8'h01;
    send(0, rlen, 1'b1, 1'b0);
    chk("R7", "pad flag", int'(err_pad), 1);
    build(1, 1);
    send(0, rlen - 1, 1'b1, 1'b0);
    chk("R8", "length not multiple", int'(err_length), 1);
    build(4, 4);
    send(0, 48, 1'b1, 1'b0);
    chk("R8", "trailer missing", int'(err_length), 1);
    build(0, 0);
    for (int i = 16; i < 4112; i++) rec[i] = 8'd0;
    rlen = 4112;
    send(0, rlen, 1'b1, 1'b0);
    check_flags("R9 oversize", model(rlen, rcnt), 1'b0);
    chk("R9", "oversize flag", int'(err_oversize), 1);

    // reframe
    build(2, 2);
    send_partial();
    chk("R10", "done on early begin", int'(rec_done), 1);
    chk("R10", "reframe flag", int'(err_reframe), 1);
    send(0, rlen, 1'b0, 1'b0);
    check_flags("R10 after reframe", model(rlen, rcnt), 1'b0);

    // random records
    for (int it = 0; it < 40; it++) begin
      int k, len;
      build(int'($urandom % 6), int'($urandom % 4));
      len = rlen;
      k = int'($urandom % 7);
      case (k)
        1: rec[rtpos] ^= 8'(1 << ($urandom % 8));
        2: rec[rtpos + 2] ^= 8'h80;
        3: rec[rtpos + 3] ^= 8'h08;
        4: if (rlen > rtpos + 4) rec[rlen - 1] = 8'h33;
        5: len = rlen - 1 - int'($urandom % 3);
        6: rec[8] ^= 8'h21;
        default: ;
      endcase
      send(0, len, 1'b1, 1'b1);
      check_flags("R3 random", model(len, rcnt), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  // recompute the trailer after header bytes were edited
  task automatic build_fix();
    logic [7:0] pe, po;
    pe = 8'd0; po = 8'd0;
    for (int i = 0; i < rtpos; i++)
      if (i % 2 == 0) pe ^= rec[i]; else po ^= rec[i];
    rec[rtpos]     = rec[5];
    rec[rtpos + 1] = rec[4];
    rec[rtpos + 2] = pe;
    rec[rtpos + 3] = po;
  endtask

  // opens a record, sends 10 bytes, then a second begin marker
  task automatic send_partial();
    obj_count = 8'(rcnt);
    evt_begin = 1'b1;
    @(negedge clk);
    evt_begin = 1'b0;
    for (int i = 0; i < 10; i++) begin
      byte_vld  = 1'b1;
      byte_data = 8'(i + 1);
      @(negedge clk);
    end
    byte_vld  = 1'b0;
    evt_begin = 1'b1;
    @(negedge clk);
    evt_begin = 1'b0;
  endtask

endmodule